// File: doc/BRIEF.md
# Hardware information read permission gate

This block answers user-level requests to read one of a few hardware information values: the CPU number, the cache-synchronisation step, the cycle counter, the counter resolution, the first performance counter and one configuration flag. A request carries a 5-bit index, the privileged-mode flag and a 32-bit per-index enable mask. The gate decides whether the read is permitted, selects the field the index names, formats it to 64 bits and returns it with a write-back enable. If the read is refused, it returns a reserved-instruction fault instead. The counters and registers themselves are kept elsewhere. Their current values are wired into the gate.

A small state machine sequences each request. In `ST_IDLE` the gate raises `req_ready`, and an accepted request (transition *accept*) latches index, mode and mask and moves to `ST_DECODE`. In `ST_DECODE` the permission check and value selection run, and their result is registered (transition *resolve*) on the way to `ST_RESPOND`. `ST_RESPOND` presents the result for exactly one cycle, then returns unconditionally to `ST_IDLE` (transition *retire*). With no request, `ST_IDLE` stays put (transition *wait*).

Top module: `hwinfo_read_gate`

## Requirements
- R1: After reset the gate is in idle: `req_ready`=1, `rsp_valid`=0, `rsp_wb_en`=0, `rsp_fault`=0, `rsp_data`=0.
- R2: A request accepted on a clock edge where `req_valid` and `req_ready` are both 1 produces `rsp_valid`=1 for exactly one cycle, two edges later. `req_ready` is 0 from the edge after acceptance until the response retires. Requests made while `req_ready`=0 are ignored and produce no response.
- R3: For index 0 to 5, a read is permitted when `priv_mode`=1, or when `enable_mask[index]`=1. Otherwise it faults.
- R4: Index 0 returns bits [9:0] of `core_base`, zero-extended to 64 bits.
- R5: Index 1 returns `sync_step`, and index 3 returns `count_res`, each zero-extended from 32 to 64 bits.
- R6: Index 2 returns `cycle_count` sign-extended from bit 31 to 64 bits.
- R7: Index 4 returns the 64-bit `perf_count0` unchanged.
- R8: Index 5 returns bit 13 of `cfg_word` in result bit 0, with all other result bits 0.
- R9: Indices 6 to 31 always fault, even when `priv_mode`=1 and every mask bit is set.
- R10: During a response exactly one of `rsp_wb_en` (permitted) and `rsp_fault` (refused) is 1. A faulting response carries `rsp_data`=0. Outside a response both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Gate can accept a request (idle) |
| req_index | input | 5 | Information register index |
| priv_mode | input | 1 | Requester is privileged; bypasses the mask |
| enable_mask | input | 32 | Per-index user read enable |
| core_base | input | 32 | Core base register (CPU number in low 10 bits) |
| sync_step | input | 32 | Cache-synchronisation step size |
| cycle_count | input | 32 | Cycle counter value |
| count_res | input | 32 | Cycle counter resolution |
| perf_count0 | input | 64 | Performance counter 0 |
| cfg_word | input | 32 | Configuration register holding the flag bit |
| rsp_valid | output | 1 | Result present (one cycle) |
| rsp_data | output | 64 | Formatted result |
| rsp_wb_en | output | 1 | Result may be written back |
| rsp_fault | output | 1 | Reserved-instruction fault |

## Verification
Every cycle, the assertions check the response pulse shape and the busy-ready relation. They also check that each response has exactly one outcome with zero data on a fault, that a privileged read of a known index never faults, and that unknown indices always fault. Only the bench scenarios can show that each index selects the right field with the right extension. The same holds for the configuration flag landing in bit 0, for a mask bit at a neighbouring position not granting access, and for the handling of a request issued while busy.

// File: rtl/hwinfo_gate_pkg.sv
package hwinfo_gate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DECODE  = 2'd1,
        ST_RESPOND = 2'd2
    } gate_state_t;

    localparam int unsigned SEL_CPUNUM    = 0;
    localparam int unsigned SEL_SYNCSTEP  = 1;
    localparam int unsigned SEL_CYCLES    = 2;
    localparam int unsigned SEL_CYCRES    = 3;
    localparam int unsigned SEL_PERF0     = 4;
    localparam int unsigned SEL_CFGFLAG   = 5;
    localparam int unsigned NUM_READABLE  = 6;

endpackage

// File: rtl/hwinfo_perm_check.sv
module hwinfo_perm_check #(
    parameter int unsigned IDX_W        = 5,
    parameter int unsigned NUM_READABLE = 6
) (
    input  logic [IDX_W-1:0]       idx,
    input  logic                   priv,
    input  logic [(1<<IDX_W)-1:0]  mask,
    output logic                   known,
    output logic                   allowed
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_READABLE - 1);

    always_comb begin
        known   = (idx <= LAST_IDX);
        allowed = known && (priv || mask[idx]);
    end
endmodule

// File: rtl/hwinfo_value_mux.sv
module hwinfo_value_mux #(
    parameter int unsigned IDX_W       = 5,
    parameter int unsigned WORD_W      = 32,
    parameter int unsigned DATA_W      = 64,
    parameter int unsigned CPUNUM_W    = 10,
    parameter int unsigned CFG_BIT_POS = 13
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] core_base,
    input  logic [WORD_W-1:0] sync_step,
    input  logic [WORD_W-1:0] cycle_count,
    input  logic [WORD_W-1:0] count_res,
    input  logic [DATA_W-1:0] perf_count0,
    input  logic [WORD_W-1:0] cfg_word,
    output logic [DATA_W-1:0] value
);
    import hwinfo_gate_pkg::*;

    localparam logic [IDX_W-1:0] K_CPUNUM   = IDX_W'(SEL_CPUNUM);
    localparam logic [IDX_W-1:0] K_SYNCSTEP = IDX_W'(SEL_SYNCSTEP);
    localparam logic [IDX_W-1:0] K_CYCLES   = IDX_W'(SEL_CYCLES);
    localparam logic [IDX_W-1:0] K_CYCRES   = IDX_W'(SEL_CYCRES);
    localparam logic [IDX_W-1:0] K_PERF0    = IDX_W'(SEL_PERF0);
    localparam logic [IDX_W-1:0] K_CFGFLAG  = IDX_W'(SEL_CFGFLAG);
    localparam int unsigned      EXT_W      = DATA_W - WORD_W;

    logic [DATA_W-1:0] cycles_sx;
    assign cycles_sx = {{EXT_W{cycle_count[WORD_W-1]}}, cycle_count};

    always_comb begin
        unique case (idx)
            K_CPUNUM:   value = DATA_W'(core_base[CPUNUM_W-1:0]);
            K_SYNCSTEP: value = DATA_W'(sync_step);
            K_CYCLES:   value = cycles_sx;
            K_CYCRES:   value = DATA_W'(count_res);
            K_PERF0:    value = perf_count0;
            K_CFGFLAG:  value = DATA_W'(cfg_word[CFG_BIT_POS]);
            default:    value = '0;
        endcase
    end
endmodule

// File: rtl/hwinfo_read_gate.sv
module hwinfo_read_gate #(
    parameter int unsigned IDX_W       = 5,
    parameter int unsigned WORD_W      = 32,
    parameter int unsigned DATA_W      = 64,
    parameter int unsigned CPUNUM_W    = 10,
    parameter int unsigned CFG_BIT_POS = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [IDX_W-1:0]       req_index,
    input  logic                   priv_mode,
    input  logic [(1<<IDX_W)-1:0]  enable_mask,
    input  logic [WORD_W-1:0]      core_base,
    input  logic [WORD_W-1:0]      sync_step,
    input  logic [WORD_W-1:0]      cycle_count,
    input  logic [WORD_W-1:0]      count_res,
    input  logic [DATA_W-1:0]      perf_count0,
    input  logic [WORD_W-1:0]      cfg_word,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_data,
    output logic                   rsp_wb_en,
    output logic                   rsp_fault
);
    import hwinfo_gate_pkg::*;

    localparam int unsigned      MASK_W   = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_READABLE - 1);

    gate_state_t state_q, state_d;

    logic [IDX_W-1:0]  lat_idx;
    logic              lat_priv;
    logic [MASK_W-1:0] lat_mask;
    logic              idx_known;
    logic              idx_allowed;
    logic [DATA_W-1:0] sel_value;
    logic [DATA_W-1:0] data_q;
    logic              wb_q;
    logic              fault_q;
    logic              unused_src_bits;

    assign unused_src_bits = ^{core_base, cfg_word, idx_known};

    hwinfo_perm_check #(
        .IDX_W        (IDX_W),
        .NUM_READABLE (NUM_READABLE)
    ) u_perm (
        .idx     (lat_idx),
        .priv    (lat_priv),
        .mask    (lat_mask),
        .known   (idx_known),
        .allowed (idx_allowed)
    );

    hwinfo_value_mux #(
        .IDX_W       (IDX_W),
        .WORD_W      (WORD_W),
        .DATA_W      (DATA_W),
        .CPUNUM_W    (CPUNUM_W),
        .CFG_BIT_POS (CFG_BIT_POS)
    ) u_mux (
        .idx         (lat_idx),
        .core_base   (core_base),
        .sync_step   (sync_step),
        .cycle_count (cycle_count),
        .count_res   (count_res),
        .perf_count0 (perf_count0),
        .cfg_word    (cfg_word),
        .value       (sel_value)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: wait, accept, resolve, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_DECODE;
            ST_DECODE:  state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_idx  <= '0;
            lat_priv <= 1'b0;
            lat_mask <= '0;
            data_q   <= '0;
            wb_q     <= 1'b0;
            fault_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                lat_idx  <= req_index;
                lat_priv <= priv_mode;
                lat_mask <= enable_mask;
            end
            if (state_q == ST_DECODE) begin
                data_q  <= idx_allowed ? sel_value : '0;
                wb_q    <= idx_allowed;
                fault_q <= !idx_allowed;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESPOND);
        rsp_wb_en = rsp_valid && wb_q;
        rsp_fault = rsp_valid && fault_q;
        rsp_data  = data_q;
    end

    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_ready_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    assert_priv_grants_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && lat_priv && lat_idx <= LAST_IDX) |-> rsp_wb_en);
    assert_unknown_faults_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && lat_idx > LAST_IDX) |-> rsp_fault);
    assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_wb_en, rsp_fault}));
    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_wb_en && !rsp_fault));
    assert_zero_on_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_data == '0));
endmodule

// File: tb/hwinfo_read_gate_test.sv
`timescale 1ns/1ps
module hwinfo_read_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [4:0]  req_index = '0;
    logic        priv_mode = 1'b0;
    logic [31:0] enable_mask = '0;
    logic [31:0] core_base = 32'hABCD_E3A7;
    logic [31:0] sync_step = 32'h8000_0040;
    logic [31:0] cycle_count = 32'h8000_0001;
    logic [31:0] count_res = 32'hF000_0002;
    logic [63:0] perf_count0 = 64'hDEAD_BEEF_0123_4567;
    logic [31:0] cfg_word = 32'h0000_2000;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        rsp_wb_en;
    logic        rsp_fault;

    int vectors = 0;
    int misses  = 0;

    always #4 clk = ~clk;

    hwinfo_read_gate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_index(req_index), .priv_mode(priv_mode), .enable_mask(enable_mask),
        .core_base(core_base), .sync_step(sync_step), .cycle_count(cycle_count),
        .count_res(count_res), .perf_count0(perf_count0), .cfg_word(cfg_word),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_wb_en(rsp_wb_en),
        .rsp_fault(rsp_fault)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [4:0] idx);
        case (idx)
            5'd0: model = {54'd0, core_base[9:0]};
            5'd1: model = {32'd0, sync_step};
            5'd2: model = {{32{cycle_count[31]}}, cycle_count};
            5'd3: model = {32'd0, count_res};
            5'd4: model = perf_count0;
            5'd5: model = {63'd0, cfg_word[13]};
            default: model = 64'd0;
        endcase
    endfunction

    // One read transaction; inputs change at negedge, outputs sampled at negedge
    task automatic do_read(input string req, input logic [4:0] idx, input logic priv,
                           input logic [31:0] mask, input logic exp_ok);
        logic [63:0] exp_data;
        exp_data = exp_ok ? model(idx) : 64'd0;
        @(negedge clk);
        req_valid = 1'b1; req_index = idx; priv_mode = priv; enable_mask = mask;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " R2 ready low while busy"}, {63'd0, req_ready}, 64'd0);
        check({req, " R2 no early response"}, {63'd0, rsp_valid}, 64'd0);
        @(negedge clk);
        check({req, " R2 response valid"}, {63'd0, rsp_valid}, 64'd1);
        check({req, " R10 wb_en"}, {63'd0, rsp_wb_en}, {63'd0, exp_ok});
        check({req, " R10 fault"}, {63'd0, rsp_fault}, {63'd0, !exp_ok});
        check({req, " data"}, rsp_data, exp_data);
        @(negedge clk);
        check({req, " R2 single pulse"}, {63'd0, rsp_valid}, 64'd0);
        check({req, " R10 flags quiet"}, {62'd0, rsp_wb_en, rsp_fault}, 64'd0);
    endtask

    task automatic t_reset;
        check("R1 ready", {63'd0, req_ready}, 64'd1);
        check("R1 valid", {63'd0, rsp_valid}, 64'd0);
        check("R1 wb_en", {63'd0, rsp_wb_en}, 64'd0);
        check("R1 fault", {63'd0, rsp_fault}, 64'd0);
        check("R1 data", rsp_data, 64'd0);
    endtask

    task automatic t_permission;
        do_read("R3 user enabled idx0", 5'd0, 1'b0, 32'h0000_0001, 1'b1);
        do_read("R3 user disabled idx1", 5'd1, 1'b0, 32'hFFFF_FFFD, 1'b0);
        do_read("R3 neighbour bit idx2", 5'd2, 1'b0, 32'h0000_0002, 1'b0);
        do_read("R3 priv bypass idx1", 5'd1, 1'b1, 32'h0000_0000, 1'b1);
    endtask

    task automatic t_fields;
        do_read("R4 cpu number", 5'd0, 1'b1, 32'h0, 1'b1);
        do_read("R5 sync step", 5'd1, 1'b0, 32'h0000_0002, 1'b1);
        do_read("R5 counter resolution", 5'd3, 1'b0, 32'h0000_0008, 1'b1);
        do_read("R6 cycles negative", 5'd2, 1'b0, 32'h0000_0004, 1'b1);
        cycle_count = 32'h1234_5678;
        do_read("R6 cycles positive", 5'd2, 1'b1, 32'h0, 1'b1);
        do_read("R7 perf counter", 5'd4, 1'b0, 32'h0000_0010, 1'b1);
        do_read("R8 cfg flag set", 5'd5, 1'b0, 32'h0000_0020, 1'b1);
        cfg_word = 32'hFFFF_DFFF;
        do_read("R8 cfg flag clear", 5'd5, 1'b1, 32'h0, 1'b1);
    endtask

    task automatic t_unknown;
        do_read("R9 idx6 priv", 5'd6, 1'b1, 32'hFFFF_FFFF, 1'b0);
        do_read("R9 idx31 priv", 5'd31, 1'b1, 32'hFFFF_FFFF, 1'b0);
        do_read("R9 idx17 user", 5'd17, 1'b0, 32'hFFFF_FFFF, 1'b0);
    endtask

    task automatic t_busy;
        int pulses;
        pulses = 0;
        @(negedge clk);
        req_valid = 1'b1; req_index = 5'd4; priv_mode = 1'b1; enable_mask = '0;
        @(negedge clk);
        req_index = 5'd6;
        for (int k = 0; k < 4; k++) begin
            if (rsp_valid) begin
                pulses++;
                check("R2 busy request ignored data", rsp_data, perf_count0);
            end
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
        end
        check("R2 one response for busy burst", 64'(pulses), 64'd1);
        check("R2 ready again", {63'd0, req_ready}, 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_permission();
        t_fields();
        t_unknown();
        t_busy();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule